// File: doc/BRIEF.md
# Memory Port Transaction Master

This block acts as the client side of a multi-port memory controller. It connects through the controller's native port, which uses an address request and an address acknowledge. A user circuit hands it one command at a time. Each command is either a write or a read, and moves either a single 32-bit word or a burst of eight 32-bit words.

The master checks the start address for alignment. For a write, it first stages every data word into the controller's write FIFO and then requests the address phase. It keeps that request raised until the controller acknowledges it. For a read, it takes words from the controller's read FIFO only while that FIFO reports data.

When a command completes, the master pulses a completion flag for one cycle. A misaligned command is refused: the master pulses an error flag and issues nothing to the controller. The master runs on the controller's own base clock and uses no synchronizers. Nothing goes to the controller until the controller reports that its initialization is done.

Top module: `mem_port_master`

## Requirements
- R1: After reset, `cmd_ready` stays low and `mc_addr_req` is never raised while `init_done` has not been seen high. `cmd_ready` rises in the cycle after the first clock edge at which `init_done` is sampled high.
- R2: Once `mc_addr_req` is raised, it stays high in every following cycle until a clock edge samples `mc_addr_ack` high. It is low in the cycle after that edge.
- R3: While `mc_addr_req` is high and not yet acknowledged, `mc_addr`, `mc_rnw` and `mc_size` do not change.
- R4: `mc_addr` equals the command address. `mc_rnw` is 1 for a read and 0 for a write. `mc_size` is 0 for one word and 1 for an eight-word burst; the command selects this with `cmd_burst`.
- R5: For a write, every word of the transfer (1 or 8) is pushed into the write FIFO before `mc_addr_req` rises. `wf_push` and `wd_ready` are low in any cycle where `wf_almost_full` is high.
- R6: For a read, `rf_pop` is high only in cycles where `rf_empty` is low. Exactly as many words as the size asks for are popped. Each popped word appears on `rd_data` with `rd_valid` high in the same cycle.
- R7: A single-word command needs address bits [1:0] equal to zero. A burst command needs bits [4:0] equal to zero. A misaligned command is accepted and then refused: `align_err` is high for exactly the next cycle, no request is raised, no FIFO is touched, and `cmd_ready` stays high.
- R8: `txn_done` is high for exactly one cycle. For a write, that is the cycle after the acknowledge edge. For a read, it is the cycle after the edge that pops the last word. `cmd_ready` is low from acceptance until that completion.
- R9: A synchronous active-high `rst` returns the block to waiting for initialization. In the cycle after a reset edge, `mc_addr_req`, `wf_push`, `rf_pop` and `cmd_ready` are low, even if a transfer was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, same as the controller base clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Controller initialization complete |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle and able to take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_burst | input | 1 | 1 = eight-word burst, 0 = single word |
| cmd_addr | input | 32 | Byte start address |
| wd_valid | input | 1 | User write word present |
| wd_ready | output | 1 | Master takes the user write word |
| wd_data | input | 32 | User write word |
| rd_valid | output | 1 | Read word present on rd_data |
| rd_data | output | 32 | Read word |
| txn_done | output | 1 | One-cycle completion pulse |
| align_err | output | 1 | One-cycle misaligned-command pulse |
| mc_addr_req | output | 1 | Address request to controller |
| mc_addr_ack | input | 1 | Address acknowledge from controller |
| mc_addr | output | 32 | Request address |
| mc_rnw | output | 1 | 1 = read, 0 = write |
| mc_size | output | 1 | 0 = one word, 1 = eight words |
| wf_push | output | 1 | Write FIFO push strobe |
| wf_data | output | 32 | Write FIFO data |
| wf_almost_full | input | 1 | Write FIFO almost full |
| rf_pop | output | 1 | Read FIFO pop strobe |
| rf_data | input | 32 | Read FIFO head word |
| rf_empty | input | 1 | Read FIFO empty |

## Verification
The hardest situation to reach is one where back-pressure and delay meet in a single command. That means a burst whose write staging stalls on almost-full several times, whose acknowledge arrives late, and whose read-back stalls on an empty FIFO between words.

The bench plays the controller. Each run applies a repeating almost-full mask and a repeating empty mask, together with a chosen acknowledge delay. It sweeps every combination of size, delay and mask, so stalls fall at every beat position.

A reset issued while a burst is stuck in staging covers the abort path.

// File: rtl/mpm_pkg.sv
package mpm_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_INIT,
    ST_IDLE,
    ST_LOAD,
    ST_REQ,
    ST_DRAIN
  } mpm_state_e;

  // number of words moved by a command of the given size
  function automatic int unsigned beats_for(input logic burst, input int unsigned burst_beats);
    return burst ? burst_beats : 32'd1;
  endfunction

  // true when the lowest nbits of v are all zero
  function automatic logic low_clear(input logic [31:0] v, input int unsigned nbits);
    logic [31:0] mask;
    mask = (32'd1 << nbits) - 32'd1;
    return (v & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/mpm_align_check.sv
module mpm_align_check #(
  parameter int unsigned WORD_LOG2  = 2,
  parameter int unsigned BURST_LOG2 = 5
) (
  input  logic [BURST_LOG2-1:0] addr_lo,
  input  logic                  burst,
  output logic                  aligned
);
  logic word_ok;
  logic burst_ok;

  generate
    if (BURST_LOG2 > WORD_LOG2) begin : g_split
      assign word_ok  = mpm_pkg::low_clear(32'(addr_lo), WORD_LOG2);
      assign burst_ok = mpm_pkg::low_clear(32'(addr_lo), BURST_LOG2);
    end else begin : g_same
      assign word_ok  = mpm_pkg::low_clear(32'(addr_lo), BURST_LOG2);
      assign burst_ok = word_ok;
    end
  endgenerate

  assign aligned = burst ? burst_ok : word_ok;
endmodule

// File: rtl/mpm_beat_counter.sv
module mpm_beat_counter #(
  parameter int unsigned MAX_BEATS = 8,
  localparam int unsigned CNT_W    = $clog2(MAX_BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             pending,
  output logic             last
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (dec && count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign pending = (count != '0);
  assign last    = (count == CNT_W'(1));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> pending);
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(MAX_BEATS));
endmodule

// File: rtl/mpm_wr_stager.sv
module mpm_wr_stager #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              wd_valid,
  input  logic [DATA_W-1:0] wd_data,
  input  logic              wf_almost_full,
  output logic              wd_ready,
  output logic              wf_push,
  output logic [DATA_W-1:0] wf_data
);
  assign wd_ready = active && !wf_almost_full;
  assign wf_push  = wd_ready && wd_valid;
  assign wf_data  = wd_data;

  // R5
  push_pause_chk: assert property (@(posedge clk) disable iff (rst)
    wf_almost_full |-> !wf_push && !wd_ready);
endmodule

// File: rtl/mpm_rd_drain.sv
module mpm_rd_drain #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              pending,
  input  logic              rf_empty,
  input  logic [DATA_W-1:0] rf_data,
  output logic              rf_pop,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  assign rf_pop   = active && pending && !rf_empty;
  assign rd_valid = rf_pop;
  assign rd_data  = rf_data;

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rf_empty |-> !rf_pop);
endmodule

// File: rtl/mem_port_master.sv
module mem_port_master #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BURST_BEATS = 8,
  parameter int unsigned WORD_LOG2   = 2,
  parameter int unsigned BURST_LOG2  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_burst,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [DATA_W-1:0] wd_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              txn_done,
  output logic              align_err,
  output logic              mc_addr_req,
  input  logic              mc_addr_ack,
  output logic [ADDR_W-1:0] mc_addr,
  output logic              mc_rnw,
  output logic              mc_size,
  output logic              wf_push,
  output logic [DATA_W-1:0] wf_data,
  input  logic              wf_almost_full,
  output logic              rf_pop,
  input  logic [DATA_W-1:0] rf_data,
  input  logic              rf_empty
);
  import mpm_pkg::*;

  localparam int unsigned CNT_W = $clog2(BURST_BEATS + 1);

  mpm_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic              rnw_q;
  logic              burst_q;
  logic              done_q;
  logic              err_q;
  logic              init_seen;

  // named internal events
  logic              cmd_fire;
  logic              align_ok;
  logic              accept_ok;
  logic              ack_ev;
  logic              push_ev;
  logic              pop_ev;
  logic              cnt_load;
  logic [CNT_W-1:0]  cnt_load_val;
  logic              beat_pending;
  logic              beat_last;
  logic              in_load;
  logic              in_drain;

  assign cmd_ready = (state == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign accept_ok = cmd_fire && align_ok;
  assign ack_ev    = (state == ST_REQ) && mc_addr_ack;
  assign in_load   = (state == ST_LOAD);
  assign in_drain  = (state == ST_DRAIN);
  assign push_ev   = wf_push;
  assign pop_ev    = rf_pop;

  assign cnt_load     = (accept_ok && cmd_write) || (ack_ev && rnw_q);
  assign cnt_load_val = (state == ST_IDLE)
                        ? CNT_W'(beats_for(cmd_burst, BURST_BEATS))
                        : CNT_W'(beats_for(burst_q, BURST_BEATS));

  mpm_align_check #(
    .WORD_LOG2 (WORD_LOG2),
    .BURST_LOG2(BURST_LOG2)
  ) i_align (
    .addr_lo(cmd_addr[BURST_LOG2-1:0]),
    .burst  (cmd_burst),
    .aligned(align_ok)
  );

  mpm_beat_counter #(
    .MAX_BEATS(BURST_BEATS)
  ) i_beats (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(cnt_load_val),
    .dec     (push_ev || pop_ev),
    .pending (beat_pending),
    .last    (beat_last)
  );

  mpm_wr_stager #(
    .DATA_W(DATA_W)
  ) i_wr (
    .clk           (clk),
    .rst           (rst),
    .active        (in_load),
    .wd_valid      (wd_valid),
    .wd_data       (wd_data),
    .wf_almost_full(wf_almost_full),
    .wd_ready      (wd_ready),
    .wf_push       (wf_push),
    .wf_data       (wf_data)
  );

  mpm_rd_drain #(
    .DATA_W(DATA_W)
  ) i_rd (
    .clk     (clk),
    .rst     (rst),
    .active  (in_drain),
    .pending (beat_pending),
    .rf_empty(rf_empty),
    .rf_data (rf_data),
    .rf_pop  (rf_pop),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT_INIT;
      addr_q    <= '0;
      rnw_q     <= 1'b0;
      burst_q   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      init_seen <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (init_done) init_seen <= 1'b1;
      case (state)
        ST_WAIT_INIT: begin
          if (init_done) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (cmd_fire) begin
            if (!align_ok) begin
              err_q <= 1'b1;
            end else begin
              addr_q  <= cmd_addr;
              rnw_q   <= !cmd_write;
              burst_q <= cmd_burst;
              state   <= cmd_write ? ST_LOAD : ST_REQ;
            end
          end
        end
        ST_LOAD: begin
          if (push_ev && beat_last) state <= ST_REQ;
        end
        ST_REQ: begin
          if (mc_addr_ack) begin
            if (rnw_q) begin
              state <= ST_DRAIN;
            end else begin
              state  <= ST_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (pop_ev && beat_last) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: state <= ST_WAIT_INIT;
      endcase
    end
  end

  assign mc_addr_req = (state == ST_REQ);
  assign mc_addr     = addr_q;
  assign mc_rnw      = rnw_q;
  assign mc_size     = burst_q;
  assign txn_done    = done_q;
  assign align_err   = err_q;

  // R1
  init_gate_chk: assert property (@(posedge clk) disable iff (rst)
    mc_addr_req |-> init_seen);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mc_addr_req && !mc_addr_ack |=> mc_addr_req);
  // R2
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    mc_addr_req && mc_addr_ack |=> !mc_addr_req);
  // R3
  req_stable_chk: assert property (@(posedge clk) disable iff (rst)
    mc_addr_req && !mc_addr_ack |=> $stable(mc_addr) && $stable(mc_rnw) && $stable(mc_size));
  // R5
  load_before_req_chk: assert property (@(posedge clk) disable iff (rst)
    mc_addr_req && !mc_rnw |-> !beat_pending);
  // R7
  err_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    align_err |-> !mc_addr_req && !wf_push && !rf_pop && cmd_ready);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    txn_done |=> !txn_done);
  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mc_addr_req || wf_push || rf_pop) |-> !cmd_ready);
  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !mc_addr_req && !wf_push && !rf_pop && !cmd_ready);
endmodule

// File: tb/test_mem_port_master.sv
`timescale 1ns/1ps
module test_mem_port_master;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        init_done = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic        cmd_burst = 1'b0;
  logic [31:0] cmd_addr = 32'd0;
  logic        wd_valid = 1'b0;
  logic [31:0] wd_data;
  logic        cmd_ready, wd_ready, rd_valid, txn_done, align_err;
  logic [31:0] rd_data;
  logic        mc_addr_req, mc_rnw, mc_size, wf_push, rf_pop;
  logic [31:0] mc_addr, wf_data;
  logic        mc_addr_ack;
  logic        wf_almost_full;
  logic        rf_block;
  logic        rf_empty;
  logic [31:0] rf_data;

  // knobs written by the stimulus block only
  int          ack_delay = 0;
  logic [7:0]  af_mask = 8'h00;
  logic [7:0]  em_mask = 8'h00;
  logic [7:0]  cur_seed = 8'h00;
  logic [31:0] cur_addr = 32'd0;

  int n_chk = 0;
  int n_bad = 0;

  mem_port_master i_mem_port_master (
    .clk(clk), .rst(rst), .init_done(init_done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_burst(cmd_burst), .cmd_addr(cmd_addr),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .txn_done(txn_done), .align_err(align_err),
    .mc_addr_req(mc_addr_req), .mc_addr_ack(mc_addr_ack), .mc_addr(mc_addr),
    .mc_rnw(mc_rnw), .mc_size(mc_size),
    .wf_push(wf_push), .wf_data(wf_data), .wf_almost_full(wf_almost_full),
    .rf_pop(rf_pop), .rf_data(rf_data), .rf_empty(rf_empty)
  );

  function automatic logic [31:0] pat(input logic [7:0] a, input logic [7:0] s, input int i);
    return {8'hD0, s, a, 8'(i)};
  endfunction

  function automatic int nbeats(input logic sz);
    return sz ? 8 : 1;
  endfunction

  // ---------------- controller model ----------------
  logic [31:0] mem [0:63];
  logic [31:0] wfifo [0:15];
  logic [31:0] rfifo [0:15];
  int          wf_cnt, rf_wp, rf_rp, wait_cnt, wr_idx, cyc;
  logic [31:0] ack_addr;
  logic        ack_rnw, ack_size;

  assign rf_empty = (rf_wp == rf_rp) || rf_block;
  assign rf_data  = rfifo[rf_rp[3:0]];
  assign wd_data  = pat(cur_addr[7:0], cur_seed, wr_idx);

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'd0;
    for (int k = 0; k < 16; k++) rfifo[k] = 32'd0;
  end

  always @(posedge clk) begin
    if (rst) begin
      mc_addr_ack    <= 1'b0;
      wf_almost_full <= 1'b0;
      rf_block       <= 1'b0;
      wf_cnt <= 0; rf_wp <= 0; rf_rp <= 0; wait_cnt <= 0; wr_idx <= 0; cyc <= 0;
    end else begin
      cyc            <= cyc + 1;
      wf_almost_full <= af_mask[(cyc + 1) % 8];
      rf_block       <= em_mask[(cyc + 1) % 8];
      if (wf_push) begin
        wfifo[wf_cnt[3:0]] <= wf_data;
        wf_cnt <= wf_cnt + 1;
        wr_idx <= wr_idx + 1;
      end
      if (rf_pop) rf_rp <= rf_rp + 1;
      if (mc_addr_req && !mc_addr_ack) begin
        if (wait_cnt == ack_delay) begin
          mc_addr_ack <= 1'b1;
          wait_cnt    <= 0;
          ack_addr    <= mc_addr;
          ack_rnw     <= mc_rnw;
          ack_size    <= mc_size;
          if (!mc_rnw) begin
            for (int k = 0; k < wf_cnt; k++) mem[6'(mc_addr[7:2] + k)] <= wfifo[k];
            wf_cnt <= 0;
            wr_idx <= 0;
          end else begin
            for (int k = 0; k < nbeats(mc_size); k++)
              rfifo[4'(rf_wp + k)] <= mem[6'(mc_addr[7:2] + k)];
            rf_wp <= rf_wp + nbeats(mc_size);
          end
        end else begin
          wait_cnt <= wait_cnt + 1;
        end
      end else begin
        mc_addr_ack <= 1'b0;
      end
    end
  end

  // ---------------- monitor ----------------
  int   n_push = 0, n_pop = 0, n_done = 0, n_err = 0, n_req = 0;
  int   v_af = 0, v_em = 0, v_rd = 0, v_done = 0, v_load = 0;
  int   v_drop = 0, v_stab = 0, v_busy = 0, v_init = 0;
  int   rd_left = 0, rd_cnt = 0;
  logic req_d = 0, ack_d = 0, rnw_d = 0, size_d = 0, ackw_d = 0, lastpop_d = 0, init_tb = 0;
  logic [31:0] addr_d = 0;

  always @(posedge clk) begin
    req_d <= mc_addr_req; ack_d <= mc_addr_ack; addr_d <= mc_addr;
    rnw_d <= mc_rnw; size_d <= mc_size;
    if (init_done) init_tb <= 1'b1;
    if (mc_addr_req && !init_tb) v_init <= v_init + 1;               // R1
    if (rst) begin
      ackw_d <= 1'b0; lastpop_d <= 1'b0; rd_left <= 0; rd_cnt <= 0;
    end else begin
      if (wf_push) n_push <= n_push + 1;
      if ((wf_push || wd_ready) && wf_almost_full) v_af <= v_af + 1;   // R5
      if (mc_addr_ack && mc_rnw && mc_addr_req) begin
        rd_left <= nbeats(mc_size);
        rd_cnt  <= 0;
      end else if (rf_pop) begin
        n_pop <= n_pop + 1;
        if (rf_empty) v_em <= v_em + 1;                                // R6
        if (!rd_valid || rd_data != pat(cur_addr[7:0], cur_seed, rd_cnt)) v_rd <= v_rd + 1;
        rd_cnt  <= rd_cnt + 1;
        rd_left <= rd_left - 1;
      end
      lastpop_d <= rf_pop && (rd_left == 1);
      ackw_d    <= mc_addr_ack && mc_addr_req && !mc_rnw;
      if (txn_done != (ackw_d || lastpop_d)) v_done <= v_done + 1;    // R8
      if (txn_done) n_done <= n_done + 1;
      if (align_err) n_err <= n_err + 1;
      if (mc_addr_req && !req_d) begin
        n_req <= n_req + 1;
        if (!mc_rnw && wr_idx != nbeats(mc_size)) v_load <= v_load + 1; // R5
      end
      if (req_d && !ack_d && !mc_addr_req) v_drop <= v_drop + 1;        // R2
      if (req_d && !ack_d && mc_addr_req &&
          (mc_addr != addr_d || mc_rnw != rnw_d || mc_size != size_d)) v_stab <= v_stab + 1; // R3
      if (mc_addr_req && cmd_ready) v_busy <= v_busy + 1;              // R8
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic bu, input logic [31:0] a, input logic [7:0] s);
    int np, npo, nd, ne, nr, guard;
    @(negedge clk);
    guard = 0;
    while (!cmd_ready && guard < 200) begin @(negedge clk); guard++; end
    np = n_push; npo = n_pop; nd = n_done; ne = n_err; nr = n_req;
    cur_addr = a; cur_seed = s;
    cmd_write = wr; cmd_burst = bu; cmd_addr = a; cmd_valid = 1'b1; wd_valid = wr;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R8 busy after accept", cmd_ready, 0);
    guard = 0;
    while (n_done == nd && guard < 600) begin @(negedge clk); guard++; end
    wd_valid = 1'b0;
    @(negedge clk);
    check(n_done - nd == 1, "R8 one done", n_done - nd, 1);
    check(ack_addr == a, "R4 address", ack_addr, a);
    check(ack_rnw == !wr, "R4 direction", ack_rnw, !wr);
    check(ack_size == bu, "R4 size", ack_size, bu);
    check(n_req - nr == 1, "R2 one request", n_req - nr, 1);
    check(n_push - np == (wr ? nbeats(bu) : 0), "R5 push count", n_push - np, wr ? nbeats(bu) : 0);
    check(n_pop - npo == (wr ? 0 : nbeats(bu)), "R6 pop count", n_pop - npo, wr ? 0 : nbeats(bu));
    check(n_err == ne, "R7 no error when aligned", n_err - ne, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] afm [0:2];
    logic [7:0] emm [0:3];
    int nr0, np0;
    afm[0] = 8'h00; afm[1] = 8'hA5; afm[2] = 8'h3C;
    emm[0] = 8'h00; emm[1] = 8'h5A; emm[2] = 8'h81; emm[3] = 8'hE7;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(cmd_ready == 0 && mc_addr_req == 0, "R9 reset ready/req", {cmd_ready, mc_addr_req}, 0);
    check(wf_push == 0 && rf_pop == 0 && txn_done == 0 && align_err == 0,
          "R9 reset strobes", {wf_push, rf_pop, txn_done, align_err}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 gated before init
    check(cmd_ready == 0, "R1 not ready before init", cmd_ready, 0);
    check(n_req == 0, "R1 no request before init", n_req, 0);
    init_done = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1, "R1 ready after init", cmd_ready, 1);

    // sweep: size x ack delay x almost-full mask, write then read back
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 4; d++)
        for (int m = 0; m < 3; m++) begin
          logic [31:0] a;
          logic [7:0]  s;
          a = b ? 32'(((d * 3 + m) * 32) % 256) : 32'(((d * 3 + m) * 4) % 256);
          s = 8'(b * 16 + d * 4 + m + 1);
          ack_delay = d; af_mask = afm[m]; em_mask = emm[d];
          run_txn(1'b1, b[0], a, s);
          run_txn(1'b0, b[0], a, s);
        end
    af_mask = 8'h00; em_mask = 8'h00; ack_delay = 1;

    // R7 misaligned sweep
    nr0 = n_req; np0 = n_push;
    for (int off = 1; off < 32; off++) begin
      @(negedge clk);
      cmd_write = off[0]; cmd_burst = 1'b1; cmd_addr = 32'(64 + off); cmd_valid = 1'b1; wd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; wd_valid = 1'b0;
      check(align_err == 1 && cmd_ready == 1, "R7 burst misaligned refused", {align_err, cmd_ready}, 2'b11);
      @(negedge clk);
      check(align_err == 0, "R7 error is one cycle", align_err, 0);
    end
    for (int off = 1; off < 4; off++) begin
      @(negedge clk);
      cmd_write = 1'b1; cmd_burst = 1'b0; cmd_addr = 32'(off); cmd_valid = 1'b1; wd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0; wd_valid = 1'b0;
      check(align_err == 1 && cmd_ready == 1, "R7 word misaligned refused", {align_err, cmd_ready}, 2'b11);
    end
    @(negedge clk);
    check(n_req == nr0 && n_push == np0, "R7 nothing issued", n_req - nr0 + n_push - np0, 0);
    run_txn(1'b1, 1'b0, 32'h0000_0044, 8'h77);   // R7 word at 4-byte boundary accepted
    run_txn(1'b0, 1'b0, 32'h0000_0044, 8'h77);

    // R9 reset during a stalled burst write
    af_mask = 8'hFF;
    @(negedge clk);
    cur_addr = 32'h40; cur_seed = 8'h99;
    cmd_write = 1'b1; cmd_burst = 1'b1; cmd_addr = 32'h40; cmd_valid = 1'b1; wd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(mc_addr_req == 0 && wf_push == 0 && rf_pop == 0 && cmd_ready == 0,
          "R9 reset aborts", {mc_addr_req, wf_push, rf_pop, cmd_ready}, 0);
    rst = 1'b0; wd_valid = 1'b0; af_mask = 8'h00;
    @(negedge clk);
    check(cmd_ready == 1, "R9 recovers to idle", cmd_ready, 1);
    run_txn(1'b1, 1'b1, 32'h60, 8'h5C);
    run_txn(1'b0, 1'b1, 32'h60, 8'h5C);

    repeat (3) @(negedge clk);
    check(v_init == 0, "R1 request before init", v_init, 0);
    check(v_drop == 0, "R2 request dropped early", v_drop, 0);
    check(v_stab == 0, "R3 fields moved during request", v_stab, 0);
    check(v_af == 0, "R5 push while almost full", v_af, 0);
    check(v_load == 0, "R5 request before data staged", v_load, 0);
    check(v_em == 0, "R6 pop while empty", v_em, 0);
    check(v_rd == 0, "R6 read data", v_rd, 0);
    check(v_done == 0, "R8 done timing", v_done, 0);
    check(v_busy == 0, "R8 ready while busy", v_busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule